// File: doc/BRIEF.md
# Multi-Mode Interval Timer

This block holds a parameterised number of identical 32-bit timer channels (three by default). Each channel owns one pin and one interrupt request. It runs in one of three modes. In waveform mode it drives a periodic pulse. In capture mode it measures the high time and the repeat time of a pulse on its pin. In event mode it counts pulses on its pin until a programmed number is reached. The counter in each channel is shared by all three modes. The mode also sets the pin direction: the pin is an output in waveform mode and an input in the other two.

Software uses a flat word-addressed register interface. Writes take effect on the clock edge. Reads are combinational from the address. Each channel has a mode register, a period register, a width register and a read-only count register. A global register holds one run bit per channel. A second global register holds one sticky event flag per channel, and software clears a flag by writing 1 to it.

Top module: `multimode_timer`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero, and all `irq`, `pin_oe` and `pin_out` bits are low.
- R2: The mode is held in bits [1:0] of a channel's mode register: 00 off, 01 waveform, 10 capture, 11 event. A channel counts only when its mode is not 00 and its run bit is set. Otherwise its count reads 0 and it raises no events. Writing the mode register also clears the count.
- R3: In waveform mode the count steps by one on every clock. On the clock after it reaches or exceeds the period, it returns to 0, and that clock edge also sets the channel's flag. One cycle therefore lasts period+1 clocks.
- R4: `pin_oe[i]` is high exactly when channel i runs in waveform mode. `pin_out[i]` is high when `pin_oe[i]` is high and the count is below the width register.
- R5: In capture mode the count steps on every clock. A synchronised rising edge copies the count into the period register and restarts the count from 0.
- R6: In capture mode a synchronised falling edge copies the count into the width register and sets the channel's flag.
- R7: In event mode the count steps only on a synchronised rising edge. If the stepped value reaches or exceeds the period, the count returns to 0 instead and the flag is set.
- R8: Pin inputs pass through two flops before edge detection. A pin level present before clock edge N acts on the state at edge N+2.
- R9: Writing 1 to bit i of the flag register clears flag i. Writing 0 has no effect. If an event occurs on the same edge as the clear, the event wins and the flag stays set.
- R10: `irq[i]` equals flag i.
- R11: Address {channel, sel} selects sel 0 mode, 1 period, 2 width, 3 count (writes to the count are ignored). Channel index NCH selects the global registers: sel 0 is the run bits and sel 1 is the flags. Every other address reads 0.
- R12: Channels are independent. Programming or stopping one channel changes no other channel's count, pin or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address {channel, sel} |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` |
| pin_in | input | NCH | Pin input levels |
| pin_out | output | NCH | Pin output levels |
| pin_oe | output | NCH | Pin output enables |
| irq | output | NCH | Per-channel interrupt requests |

## Verification
A fault in a channel's count or mode register shows up at the ports within one clock in waveform mode, as a wrong `pin_out` level and a wrong count readback. It also appears within one period as an `irq` rise on the wrong edge. In the two input modes, a wrong count stays hidden until the next synchronised pin edge. At that edge it lands as a wrong value in the period or width register, or as a flag set too early or too late. So the reference model follows every edge and compares the count on every clock. Synchroniser faults show as a shift of whole clocks in when a capture or event happens.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_OFF = 2'b00,
    TM_PWM = 2'b01,
    TM_CAP = 2'b10,
    TM_EVT = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_PER   = 2'd1;
  localparam logic [1:0] SEL_WID   = 2'd2;
  localparam logic [1:0] SEL_CNT   = 2'd3;
  localparam logic [1:0] SEL_RUN   = 2'd0;
  localparam logic [1:0] SEL_FLAG  = 2'd1;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rise,
  input  logic          fall,
  input  logic          mode_we,
  input  logic          per_we,
  input  logic          wid_we,
  input  logic [CW-1:0] wdata,
  output logic [1:0]    mode,
  output logic [CW-1:0] period,
  output logic [CW-1:0] width,
  output logic [CW-1:0] count,
  output logic          evt,
  output logic          pout,
  output logic          poe
);
  tmr_mode_e     mode_q, mode_d;
  logic [CW-1:0] per_q, per_d;
  logic [CW-1:0] wid_q, wid_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;
  logic          active;
  logic          per_ld, wid_ld;

  assign active  = run && (mode_q != TM_OFF);
  assign cnt_inc = cnt_q + {{(CW-1){1'b0}}, 1'b1};

  always_comb begin
    mode_d = mode_q;
    per_d  = per_q;
    wid_d  = wid_q;
    cnt_d  = cnt_q;
    evt    = 1'b0;
    per_ld = per_we;
    wid_ld = wid_we;
    if (per_we) per_d = wdata;
    if (wid_we) wid_d = wdata;
    if (!active) begin
      cnt_d = '0;
    end else begin
      unique case (mode_q)
        TM_PWM: begin
          if (cnt_q >= per_q) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        TM_CAP: begin
          cnt_d = cnt_inc;
          if (rise) begin
            per_d  = cnt_q;
            per_ld = 1'b1;
            cnt_d  = '0;
          end
          if (fall) begin
            wid_d  = cnt_q;
            wid_ld = 1'b1;
            evt    = 1'b1;
          end
        end
        TM_EVT: begin
          if (rise) begin
            if (cnt_inc >= per_q) begin
              cnt_d = '0;
              evt   = 1'b1;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        default: cnt_d = '0;
      endcase
    end
    if (mode_we) begin
      mode_d = tmr_mode_e'(wdata[1:0]);
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_OFF;
      per_q  <= '0;
      wid_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (per_ld)  per_q  <= per_d;
      if (wid_ld)  wid_q  <= wid_d;
      cnt_q <= cnt_d;
    end
  end

  assign mode   = mode_q;
  assign period = per_q;
  assign width  = wid_q;
  assign count  = cnt_q;
  assign poe    = run && (mode_q == TM_PWM);
  assign pout   = poe && (cnt_q < wid_q);
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 32,
  localparam int CH_AW = $clog2(NCH + 1),
  localparam int AW    = CH_AW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe,
  output logic [NCH-1:0] irq
);
  logic [CH_AW-1:0] ch_f;
  logic [1:0]       sel_f;
  logic             glb_hit;
  logic [NCH-1:0]   run_q, run_d;
  logic [NCH-1:0]   flag_q, flag_d;
  logic [NCH-1:0]   evt_w, rise_w, fall_w;
  logic [NCH-1:0][1:0]    mode_w;
  logic [NCH-1:0][CW-1:0] per_w, wid_w, cnt_w;

  assign ch_f    = reg_addr[AW-1:2];
  assign sel_f   = reg_addr[1:0];
  assign glb_hit = (ch_f == CH_AW'(NCH));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = reg_we && (ch_f == CH_AW'(i));

    tmr_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_in[i]),
      .rise (rise_w[i]),
      .fall (fall_w[i])
    );

    tmr_channel #(.CW(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q[i]),
      .rise   (rise_w[i]),
      .fall   (fall_w[i]),
      .mode_we(hit && (sel_f == SEL_MODE)),
      .per_we (hit && (sel_f == SEL_PER)),
      .wid_we (hit && (sel_f == SEL_WID)),
      .wdata  (reg_wdata),
      .mode   (mode_w[i]),
      .period (per_w[i]),
      .width  (wid_w[i]),
      .count  (cnt_w[i]),
      .evt    (evt_w[i]),
      .pout   (pin_out[i]),
      .poe    (pin_oe[i])
    );
  end

  always_comb begin
    run_d  = run_q;
    flag_d = flag_q;
    if (reg_we && glb_hit && (sel_f == SEL_RUN))  run_d  = reg_wdata[NCH-1:0];
    if (reg_we && glb_hit && (sel_f == SEL_FLAG)) flag_d = flag_q & ~reg_wdata[NCH-1:0];
    flag_d = flag_d | evt_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (glb_hit) begin
      if (sel_f == SEL_RUN)  reg_rdata = CW'(run_q);
      if (sel_f == SEL_FLAG) reg_rdata = CW'(flag_q);
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_f == CH_AW'(i)) begin
          unique case (sel_f)
            SEL_MODE: reg_rdata = CW'(mode_w[i]);
            SEL_PER:  reg_rdata = per_w[i];
            SEL_WID:  reg_rdata = wid_w[i];
            default:  reg_rdata = cnt_w[i];
          endcase
        end
      end
    end
  end

  assign irq = flag_q;
endmodule

// File: rtl/multimode_timer_checker.sv
module multimode_timer_checker #(
  parameter int NCH = 3,
  parameter int CW  = 32,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [AW-1:0]          reg_addr,
  input logic [NCH-1:0]         clr_bits,
  input logic [NCH-1:0]         pin_out,
  input logic [NCH-1:0]         pin_oe,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0][1:0]    mode,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] per
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'((NCH << 2) | 1);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_oe_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_oe[i]) |-> $past(reg_we));

    p_out_needs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out[i] |-> pin_oe[i]);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !(reg_we && reg_addr == FLAG_ADDR && clr_bits[i])) |=> irq[i]);

    p_flag_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(run[i]));

    p_pwm_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == 2'b01 && $past(mode[i]) == 2'b01 && !$past(reg_we)) |-> (cnt[i] <= per[i]));
  end
endmodule

bind multimode_timer multimode_timer_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_we  (reg_we),
  .reg_addr(reg_addr),
  .clr_bits(reg_wdata[NCH-1:0]),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .run     (run_q),
  .mode    (mode_w),
  .cnt     (cnt_w),
  .per     (per_w)
);

// File: tb/multimode_timer_bench.sv
module multimode_timer_bench;
  localparam int CLK_P = 10;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [2:0]  pin_in, pin_out, pin_oe, irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic [1:0]  m_mode [NCH];
  logic [31:0] m_per  [NCH];
  logic [31:0] m_wid  [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [2:0]  m_sy   [NCH];
  logic [2:0]  m_run, m_flag;

  always #(CLK_P/2) clk = ~clk;

  multimode_timer u_multimode_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural reference, updated on every clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = '0; m_flag = '0;
      for (int i = 0; i < NCH; i++) begin
        m_mode[i] = 0; m_per[i] = 0; m_wid[i] = 0; m_cnt[i] = 0; m_sy[i] = 0;
      end
    end else begin
      logic [2:0] ev;
      ev = '0;
      for (int i = 0; i < NCH; i++) begin
        logic r, f;
        logic [31:0] nx;
        r = m_sy[i][1] & ~m_sy[i][2];
        f = ~m_sy[i][1] & m_sy[i][2];
        nx = m_cnt[i] + 1;
        if (reg_we && reg_addr == 4'(i*4+1)) m_per[i] = reg_wdata;
        if (reg_we && reg_addr == 4'(i*4+2)) m_wid[i] = reg_wdata;
        if (!(m_run[i] && m_mode[i] != 0)) m_cnt[i] = 0;
        else if (m_mode[i] == 1) begin
          if (m_cnt[i] >= m_per[i]) begin m_cnt[i] = 0; ev[i] = 1; end
          else m_cnt[i] = nx;
        end else if (m_mode[i] == 2) begin
          if (r) begin m_per[i] = m_cnt[i]; m_cnt[i] = 0; end
          else m_cnt[i] = nx;
          if (f) begin m_wid[i] = nx - 1; ev[i] = 1; end
        end else if (r) begin
          if (nx >= m_per[i]) begin m_cnt[i] = 0; ev[i] = 1; end
          else m_cnt[i] = nx;
        end
        if (reg_we && reg_addr == 4'(i*4)) begin
          m_mode[i] = reg_wdata[1:0]; m_cnt[i] = 0;
        end
        m_sy[i] = {m_sy[i][1:0], pin_in[i]};
      end
      if (reg_we && reg_addr == 4'd13) m_flag = m_flag & ~reg_wdata[2:0];
      m_flag = m_flag | ev;
      if (reg_we && reg_addr == 4'd12) m_run = reg_wdata[2:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    int c;
    c = int'(a[3:2]);
    if (c == NCH) return (a[1:0] == 0) ? 32'(m_run) : (a[1:0] == 1) ? 32'(m_flag) : 32'd0;
    case (a[1:0])
      2'd0: return 32'(m_mode[c]);
      2'd1: return m_per[c];
      2'd2: return m_wid[c];
      default: return m_cnt[c];
    endcase
  endfunction

  task automatic chk(input string what, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
    for (int i = 0; i < NCH; i++) begin
      logic oe;
      oe = m_run[i] && m_mode[i] == 1;
      chk($sformatf("pin_oe[%0d]", i), cur_req, 32'(pin_oe[i]), 32'(oe));
      chk($sformatf("pin_out[%0d]", i), cur_req, 32'(pin_out[i]), 32'(oe && m_cnt[i] < m_wid[i]));
    end
    chk("irq", "R10", 32'(irq), 32'(m_flag));
    chk($sformatf("rdata@%0d", reg_addr), cur_req, reg_rdata, m_read(reg_addr));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n, input logic [3:0] a);
    reg_addr = a;
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic pulse(input int ch, input int hi, input int lo, input logic [3:0] a);
    pin_in[ch] = 1'b1; idle(hi, a);
    pin_in[ch] = 1'b0; idle(lo, a);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
    cur_req = "R1";
    idle(3, 4'd3);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) idle(1, 4'(a));

    cur_req = "R11";
    wr(4'd1, 32'd7); wr(4'd2, 32'd3); wr(4'd3, 32'd99);
    for (int a = 0; a < 16; a++) idle(1, 4'(a));

    cur_req = "R2";                      // mode set, run bit off: count stays 0
    wr(4'd0, 32'd1); idle(5, 4'd3);

    cur_req = "R3";
    wr(4'd12, 32'd1); idle(20, 4'd3);
    cur_req = "R4";
    idle(10, 4'd0);

    cur_req = "R9";                      // clear every cycle: coincident set must win
    for (int k = 0; k < 20; k++) wr(4'd13, 32'd1);
    idle(12, 4'd13);

    cur_req = "R7";                      // channel 1 counts pin events, period 3
    wr(4'd5, 32'd3); wr(4'd4, 32'd3); wr(4'd12, 32'd3);
    for (int n = 0; n < 8; n++) pulse(1, 2, 3, 4'd7);

    cur_req = "R5";                      // channel 2 capture
    wr(4'd8, 32'd2); wr(4'd12, 32'd7);
    for (int n = 0; n < 4; n++) pulse(2, 4, 6, 4'd9);
    cur_req = "R6";
    for (int n = 0; n < 4; n++) pulse(2, 5, 3, 4'd10);
    cur_req = "R8";                      // single-clock pulse still seen after two flops
    pulse(2, 1, 8, 4'd10);
    pulse(2, 2, 7, 4'd9);

    cur_req = "R12";                     // stop channel 0, others keep going
    wr(4'd0, 32'd0);
    for (int n = 0; n < 3; n++) begin pulse(1, 2, 2, 4'd7); pulse(2, 3, 4, 4'd11); end
    idle(4, 4'd3);

    cur_req = "R2";                      // run bit off for channel 2 clears its count
    wr(4'd12, 32'd2);
    pulse(2, 3, 3, 4'd11);
    wr(4'd13, 32'd7); idle(4, 4'd13);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule